// File: doc/BRIEF.md
# Operand-Isolated Adder Stage

This block is one pipeline stage of a processor datapath. Two decode lines arrive each cycle. A major steering line says whether the stage executes at all. A local steering line picks between two results. The first is an add of operands `in_a` and `in_b`, each passed through a masking multiplexer. The second is a plain move of `in_c`. The picked value is written into an enabled pipeline register.

Around the adder sits isolation logic that freezes the adder operands on cycles where the sum cannot reach the register. This cuts switching in the adder without changing anything that is stored. The isolating signals are the decode lines already present, or a single AND of two of them. No detection logic is added.

Two parameters set the isolation. `ISO_MODE` picks where the gates sit and which signal drives them. `ISO_STYLE` picks what a frozen operand shows: all zeros, all ones, or its last passed value. A minimum-width parameter turns isolation off for narrow instances. The post-isolation adder operands are brought out so that the freezing can be observed.

Top module: `iso_stage`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `result_o` to zero and clears every hold register, so a last-value instance shows zero on a frozen operand after reset.
- R2: The register write enable equals `steer_major`. While `steer_major` is low, `result_o` keeps its value across the edge.
- R3: At an edge with `steer_major` high, `result_o` takes `(in_a + in_b) mod 2^WIDTH` when `steer_local` is high, and `in_c` when `steer_local` is low.
- R4: `result_o` is bit-identical across every `ISO_MODE` / `ISO_STYLE` combination for the same input sequence.
- R5: With `ISO_MODE` = 1 (coarse), `in_a` and `in_b` are gated at the block inputs by `steer_major`, before masking. The adder operands are then `opnd_a = (major&local) ? gate(in_a) : 0` and `opnd_b = local ? gate(in_b) : 0`.
- R6: With `ISO_MODE` = 2 (observability-based), both masked operands are gated just before the adder by `steer_major & steer_local`.
- R7: With `ISO_MODE` = 3 (fine), operand A is already masked by the sum select, so it is gated by `steer_major` alone. Operand B is gated by `steer_major & steer_local`.
- R8: With `ISO_STYLE` = 0, a gated operand reads all zeros while its isolating signal is low.
- R9: With `ISO_STYLE` = 1, a gated operand reads all ones while its isolating signal is low.
- R10: With `ISO_STYLE` = 2, a gated operand reads the value it last passed at an edge where its isolating signal was high. While that signal stays low, the operand does not change.
- R11: With `ISO_MODE` = 0, no gating occurs. The operands are `opnd_a = (major&local) ? in_a : 0` and `opnd_b = local ? in_b : 0`.
- R12: When `WIDTH < MIN_ISO_WIDTH`, the block behaves as `ISO_MODE` = 0 whatever mode is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| steer_major | input | 1 | Stage executes this cycle; also the write enable |
| steer_local | input | 1 | High picks the sum, low picks the move operand |
| in_a | input | WIDTH | First adder source |
| in_b | input | WIDTH | Second adder source |
| in_c | input | WIDTH | Move source |
| result_o | output | WIDTH | Pipeline register contents |
| opnd_a | output | WIDTH | Adder operand A after masking and isolation |
| opnd_b | output | WIDTH | Adder operand B after masking and isolation |

## Verification
The bound checker watches, on every cycle, the register semantics: the reset clear, the hold while the stage is idle, and the sum and move write-back taken from the previous cycle's inputs. For the late-gating modes it also checks the parked constant of the zero and ones styles and that an operand whose isolating signal stays low does not move. The exact operand values in coarse mode depend on the ordering of gating and masking. That ordering, the last-value contents, the inertness of narrow instances, and bit-identical results across six parameter sets are shown only by the bench. The bench runs all six instances side by side on directed and random steering patterns against a reference model.

// File: rtl/iso_pkg.sv
`timescale 1ns/1ps
package iso_pkg;

    // Where the isolating gates sit and which decode line drives them.
    typedef enum int {
        ISO_NONE   = 0,
        ISO_COARSE = 1,
        ISO_ODC    = 2,
        ISO_FINE   = 3
    } iso_mode_e;

    // Value shown by a gated operand while its isolating signal is low.
    typedef enum int {
        HOLD_ZERO = 0,
        HOLD_ONES = 1,
        HOLD_LAST = 2
    } iso_style_e;

endpackage

// File: rtl/iso_steer_decode.sv
`timescale 1ns/1ps
module iso_steer_decode (
    input  logic steer_major,
    input  logic steer_local,
    output logic sel_sum,
    output logic sel_b,
    output logic wr_en
);

    // The sum reaches the register only when the stage runs and picks it.
    always_comb begin
        sel_sum = steer_major & steer_local;
        sel_b   = steer_local;
        wr_en   = steer_major;
    end

endmodule

// File: rtl/iso_gate.sv
`timescale 1ns/1ps
module iso_gate
    import iso_pkg::*;
#(
    parameter int         W      = 32,
    parameter iso_style_e STYLE  = HOLD_ZERO,
    parameter bit         ACTIVE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pass,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (!ACTIVE) begin : g_wire
            logic unused_ctl;
            assign unused_ctl = ^{clk, rst, pass};
            assign dout = din;
        end else if (STYLE == HOLD_LAST) begin : g_last
            typedef struct packed {
                logic [W-1:0] held;
            } hold_t;

            hold_t h_d;
            hold_t h_q;

            always_comb begin
                h_d = h_q;
                if (pass) begin
                    h_d.held = din;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    h_q <= '0;
                end else begin
                    h_q <= h_d;
                end
            end

            assign dout = pass ? din : h_q.held;
        end else begin : g_const
            localparam logic [W-1:0] PARK = (STYLE == HOLD_ONES) ? {W{1'b1}} : {W{1'b0}};
            logic unused_ctl;
            assign unused_ctl = ^{clk, rst};
            assign dout = pass ? din : PARK;
        end
    endgenerate

endmodule

// File: rtl/iso_stage.sv
`timescale 1ns/1ps
module iso_stage
    import iso_pkg::*;
#(
    parameter int         WIDTH         = 32,
    parameter iso_mode_e  ISO_MODE      = ISO_FINE,
    parameter iso_style_e ISO_STYLE     = HOLD_LAST,
    parameter int         MIN_ISO_WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             steer_major,
    input  logic             steer_local,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [WIDTH-1:0] in_c,
    output logic [WIDTH-1:0] result_o,
    output logic [WIDTH-1:0] opnd_a,
    output logic [WIDTH-1:0] opnd_b
);

    localparam int N_OPND   = 2;
    localparam bit ISO_ON   = (ISO_MODE != ISO_NONE) && (WIDTH >= MIN_ISO_WIDTH);
    localparam bit EARLY_ON = ISO_ON && (ISO_MODE == ISO_COARSE);
    localparam bit LATE_ON  = ISO_ON && ((ISO_MODE == ISO_ODC) || (ISO_MODE == ISO_FINE));

    typedef struct packed {
        logic [WIDTH-1:0] result;
    } stage_t;

    stage_t st_d;
    stage_t st_q;

    logic sel_sum;
    logic sel_b;
    logic wr_en;

    logic [N_OPND-1:0][WIDTH-1:0] raw;
    logic [N_OPND-1:0][WIDTH-1:0] early;
    logic [N_OPND-1:0][WIDTH-1:0] masked;
    logic [N_OPND-1:0][WIDTH-1:0] late;
    logic [N_OPND-1:0]            mask_sel;
    logic [N_OPND-1:0]            late_pass;
    logic [WIDTH-1:0]             sum;

    iso_steer_decode u_decode (
        .steer_major (steer_major),
        .steer_local (steer_local),
        .sel_sum     (sel_sum),
        .sel_b       (sel_b),
        .wr_en       (wr_en)
    );

    assign raw[0]      = in_a;
    assign raw[1]      = in_b;
    assign mask_sel[0] = sel_sum;
    assign mask_sel[1] = sel_b;

    // Operand A is already zeroed by sel_sum, so fine mode drops that term.
    assign late_pass[0] = (ISO_MODE == ISO_FINE) ? wr_en : (sel_sum & wr_en);
    assign late_pass[1] = sel_sum & wr_en;

    generate
        for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
            // Gate at the block input, driven by the major steering line.
            iso_gate #(
                .W      (WIDTH),
                .STYLE  (ISO_STYLE),
                .ACTIVE (EARLY_ON)
            ) u_early (
                .clk  (clk),
                .rst  (rst),
                .pass (steer_major),
                .din  (raw[i]),
                .dout (early[i])
            );

            assign masked[i] = mask_sel[i] ? early[i] : '0;

            // Gate right in front of the adder, driven by the observability term.
            iso_gate #(
                .W      (WIDTH),
                .STYLE  (ISO_STYLE),
                .ACTIVE (LATE_ON)
            ) u_late (
                .clk  (clk),
                .rst  (rst),
                .pass (late_pass[i]),
                .din  (masked[i]),
                .dout (late[i])
            );
        end
    endgenerate

    assign opnd_a = late[0];
    assign opnd_b = late[1];
    assign sum    = late[0] + late[1];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.result = sel_sum ? sum : in_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;

endmodule

// File: rtl/iso_stage_chk.sv
`timescale 1ns/1ps
module iso_stage_chk
    import iso_pkg::*;
#(
    parameter int         WIDTH         = 32,
    parameter iso_mode_e  ISO_MODE      = ISO_FINE,
    parameter iso_style_e ISO_STYLE     = HOLD_LAST,
    parameter int         MIN_ISO_WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             steer_major,
    input logic             steer_local,
    input logic [WIDTH-1:0] in_a,
    input logic [WIDTH-1:0] in_b,
    input logic [WIDTH-1:0] in_c,
    input logic [WIDTH-1:0] result_o,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b
);

    localparam bit LATE_ON = (WIDTH >= MIN_ISO_WIDTH) &&
                             ((ISO_MODE == ISO_ODC) || (ISO_MODE == ISO_FINE));

    logic iso_a;
    logic iso_b;
    logic past_ok = 1'b0;

    assign iso_a = (ISO_MODE == ISO_FINE) ? steer_major : (steer_major & steer_local);
    assign iso_b = steer_major & steer_local;

    always_ff @(posedge clk) begin
        past_ok <= !rst;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (result_o == '0));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !steer_major |=> $stable(result_o));

    a_r3_sum_store: assert property (@(posedge clk) disable iff (rst)
        (steer_major && steer_local) |=> (result_o == WIDTH'($past(in_a) + $past(in_b))));

    a_r3_move_store: assert property (@(posedge clk) disable iff (rst)
        (steer_major && !steer_local) |=> (result_o == $past(in_c)));

    a_r8_zero_park_a: assert property (@(posedge clk) disable iff (rst)
        (LATE_ON && ISO_STYLE == HOLD_ZERO && !iso_a) |-> (opnd_a == '0));

    a_r8_zero_park_b: assert property (@(posedge clk) disable iff (rst)
        (LATE_ON && ISO_STYLE == HOLD_ZERO && !iso_b) |-> (opnd_b == '0));

    a_r9_ones_park_a: assert property (@(posedge clk) disable iff (rst)
        (LATE_ON && ISO_STYLE == HOLD_ONES && !iso_a) |-> (opnd_a == '1));

    a_r9_ones_park_b: assert property (@(posedge clk) disable iff (rst)
        (LATE_ON && ISO_STYLE == HOLD_ONES && !iso_b) |-> (opnd_b == '1));

    a_r10_frozen_a: assert property (@(posedge clk) disable iff (rst)
        (LATE_ON && past_ok && !iso_a && !$past(iso_a)) |-> $stable(opnd_a));

    a_r10_frozen_b: assert property (@(posedge clk) disable iff (rst)
        (LATE_ON && past_ok && !iso_b && !$past(iso_b)) |-> $stable(opnd_b));

endmodule

bind iso_stage iso_stage_chk #(
    .WIDTH         (WIDTH),
    .ISO_MODE      (ISO_MODE),
    .ISO_STYLE     (ISO_STYLE),
    .MIN_ISO_WIDTH (MIN_ISO_WIDTH)
) u_iso_chk (
    .clk         (clk),
    .rst         (rst),
    .steer_major (steer_major),
    .steer_local (steer_local),
    .in_a        (in_a),
    .in_b        (in_b),
    .in_c        (in_c),
    .result_o    (result_o),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b)
);

// File: tb/iso_stage_bench.sv
`timescale 1ns/1ps
module iso_stage_bench;
    import iso_pkg::*;

    localparam int NCFG = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        steer_major = 1'b0;
    logic        steer_local = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic [31:0] in_c = '0;

    logic [31:0] res_w [NCFG];
    logic [31:0] oa_w  [NCFG];
    logic [31:0] ob_w  [NCFG];

    // Per-instance configuration: mode, style, isolation actually on.
    int    cm  [NCFG] = '{3, 0, 1, 2, 1, 2};
    int    cs  [NCFG] = '{2, 0, 1, 0, 2, 1};
    bit    con [NCFG] = '{1, 0, 1, 1, 1, 0};
    string tag [NCFG] = '{"R7/R10", "R11", "R5/R9", "R6/R8", "R5/R10", "R12"};

    logic [31:0] held_a [NCFG];
    logic [31:0] held_b [NCFG];
    logic [31:0] mres;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    iso_stage u_iso_stage (
        .clk(clk), .rst(rst), .steer_major(steer_major), .steer_local(steer_local),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .result_o(res_w[0]), .opnd_a(oa_w[0]), .opnd_b(ob_w[0]));

    iso_stage #(.ISO_MODE(ISO_NONE), .ISO_STYLE(HOLD_ZERO)) u_iso_stage_none (
        .clk(clk), .rst(rst), .steer_major(steer_major), .steer_local(steer_local),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .result_o(res_w[1]), .opnd_a(oa_w[1]), .opnd_b(ob_w[1]));

    iso_stage #(.ISO_MODE(ISO_COARSE), .ISO_STYLE(HOLD_ONES)) u_iso_stage_coarse_ones (
        .clk(clk), .rst(rst), .steer_major(steer_major), .steer_local(steer_local),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .result_o(res_w[2]), .opnd_a(oa_w[2]), .opnd_b(ob_w[2]));

    iso_stage #(.ISO_MODE(ISO_ODC), .ISO_STYLE(HOLD_ZERO)) u_iso_stage_odc_zero (
        .clk(clk), .rst(rst), .steer_major(steer_major), .steer_local(steer_local),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .result_o(res_w[3]), .opnd_a(oa_w[3]), .opnd_b(ob_w[3]));

    iso_stage #(.ISO_MODE(ISO_COARSE), .ISO_STYLE(HOLD_LAST)) u_iso_stage_coarse_last (
        .clk(clk), .rst(rst), .steer_major(steer_major), .steer_local(steer_local),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .result_o(res_w[4]), .opnd_a(oa_w[4]), .opnd_b(ob_w[4]));

    iso_stage #(.ISO_MODE(ISO_ODC), .ISO_STYLE(HOLD_ONES), .MIN_ISO_WIDTH(64)) u_iso_stage_narrow (
        .clk(clk), .rst(rst), .steer_major(steer_major), .steer_local(steer_local),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .result_o(res_w[5]), .opnd_a(oa_w[5]), .opnd_b(ob_w[5]));

    function automatic logic [31:0] park(logic [31:0] v, logic pass, int style, logic [31:0] held);
        if (pass) return v;
        if (style == 0) return 32'h0;
        if (style == 1) return 32'hFFFF_FFFF;
        return held;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < NCFG; k++) begin
            held_a[k] = '0;
            held_b[k] = '0;
        end
        mres = '0;
    endtask

    // Drive one cycle, check outputs, then advance the model past the next edge.
    task automatic step(bit maj, bit loc, logic [31:0] a, logic [31:0] b, logic [31:0] c);
        logic s1;
        logic pa;
        logic pb;
        logic [31:0] ma;
        logic [31:0] mb;
        logic [31:0] ea;
        logic [31:0] eb;
        logic [31:0] nha [NCFG];
        logic [31:0] nhb [NCFG];
        @(negedge clk);
        steer_major = maj;
        steer_local = loc;
        in_a = a;
        in_b = b;
        in_c = c;
        #1;
        s1 = maj & loc;
        for (int k = 0; k < NCFG; k++) begin
            nha[k] = held_a[k];
            nhb[k] = held_b[k];
            if (!con[k]) begin
                ea = s1 ? a : 32'h0;
                eb = loc ? b : 32'h0;
            end else if (cm[k] == 1) begin
                ea = s1 ? park(a, maj, cs[k], held_a[k]) : 32'h0;
                eb = loc ? park(b, maj, cs[k], held_b[k]) : 32'h0;
                if (maj) begin
                    nha[k] = a;
                    nhb[k] = b;
                end
            end else begin
                ma = s1 ? a : 32'h0;
                mb = loc ? b : 32'h0;
                pa = (cm[k] == 3) ? maj : s1;
                pb = s1;
                ea = park(ma, pa, cs[k], held_a[k]);
                eb = park(mb, pb, cs[k], held_b[k]);
                if (pa) nha[k] = ma;
                if (pb) nhb[k] = mb;
            end
            check(oa_w[k] === ea, tag[k], "opnd_a", oa_w[k], ea);
            check(ob_w[k] === eb, tag[k], "opnd_b", ob_w[k], eb);
            check(res_w[k] === mres, "R2/R3", "result_o", res_w[k], mres);
            if (k != 1) begin
                check(res_w[k] === res_w[1], "R4", "result vs unisolated", res_w[k], res_w[1]);
            end
        end
        for (int k = 0; k < NCFG; k++) begin
            held_a[k] = nha[k];
            held_b[k] = nhb[k];
        end
        if (maj) mres = s1 ? (a + b) : c;
    endtask

    initial begin : watchdog
        #3_000_000;
        if (!done) begin
            fails++;
            total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin : stimulus
        logic [31:0] seed;
        seed = $urandom(32'd1234);
        model_reset();
        rst = 1'b1;
        in_a = 32'hDEAD_BEEF;
        in_b = 32'h1234_5678;
        in_c = 32'hCAFE_0000;
        repeat (3) @(negedge clk);
        // R1: all registers cleared, last-value holds read zero while parked.
        for (int k = 0; k < NCFG; k++) begin
            check(res_w[k] === 32'h0, "R1", "result after reset", res_w[k], 32'h0);
        end
        check(oa_w[0] === 32'h0, "R1", "fine hold A after reset", oa_w[0], 32'h0);
        check(ob_w[0] === 32'h0, "R1", "fine hold B after reset", ob_w[0], 32'h0);
        check(oa_w[4] === 32'h0, "R1", "coarse hold A after reset", oa_w[4], 32'h0);
        rst = 1'b0;

        // Directed corners.
        step(1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 32'h5555_5555); // R3 wrap to zero
        step(1'b0, 1'b1, 32'h0F0F_0F0F, 32'hA5A5_A5A5, 32'h1111_1111); // R2 hold, R5 B parked
        step(1'b0, 1'b1, 32'h7777_7777, 32'h3C3C_3C3C, 32'h2222_2222); // R10 still frozen
        step(1'b1, 1'b0, 32'h1357_9BDF, 32'h2468_ACE0, 32'h8765_4321); // R3 move, R7 A passes
        step(1'b1, 1'b1, 32'h0000_0010, 32'h0000_0020, 32'h9999_9999);
        step(1'b0, 1'b0, 32'hFFFF_0000, 32'h0000_FFFF, 32'h4444_4444);
        step(1'b1, 1'b0, 32'h8000_0000, 32'h8000_0000, 32'hFFFF_FFFF);
        step(1'b1, 1'b1, 32'h8000_0000, 32'h8000_0000, 32'h0);

        // Mid-run reset: result and holds return to zero.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        steer_major = 1'b0;
        steer_local = 1'b0;
        #1;
        check(res_w[0] === 32'h0, "R1", "result after mid-run reset", res_w[0], 32'h0);

        for (int n = 0; n < 3000; n++) begin
            logic [3:0] r;
            r = 4'($urandom);
            step(r < 4'd9, r[0] | (r > 4'd12), $urandom, $urandom, $urandom);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule